// File: doc/BRIEF.md
# Block-Parallel Look-Ahead Biquad Filter

This block is a second-order recursive filter with one zero and two poles. It accepts M input samples per clock and returns M filtered samples per clock. The serial recursion is y[n] = b0*x[n] + b1*x[n-1] + a1*y[n-1] + a2*y[n-2]. The block does not run that loop sample by sample. Instead, every output in a block is formed in one step from the two newest outputs of the previous block and the inputs that arrived since then. The only values carried from one clock to the next are those two outputs and the last input sample.

The weights for that look-ahead form are computed before data flows and written through a small coefficient port:

- the zero-part taps b0 and b1;
- the impulse response g[k] of the pole-only recursion;
- the weights P[m] and Q[m] that carry the two stored outputs forward to lane m.

Because the feedback that crosses each clock boundary behaves like the original poles raised to the M-th power, its effective poles sit further inside the unit circle. The state is held with G extra fraction bits and saturates at a wider width than the output. Each output lane is rounded and clipped to the output width.

Top module: `lookahead_iir2`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `out_valid` low, every output lane zero, and cleared internal state (stored outputs and stored input).
- R2: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. Lane k (bits k*DW and up) holds the k-th oldest sample of its block, on both input and output.
- R3: Every output lane equals, within one LSB, the serial recursion y[n] = b0*x[n] + b1*x[n-1] + a1*y[n-1] + a2*y[n-2] run over the whole valid sample stream and then rounded and saturated.
- R4: A cycle with `in_valid` low changes neither the output lanes nor the stored state, whatever its `in_data`. Filtering resumes on the next valid block as if no gap had occurred.
- R5: An output whose rounded value exceeds the signed DW-bit range is clipped to +(2^(DW-1)-1) or -2^(DW-1).
- R6: The conversion from the internal value (G fraction bits) to an output lane rounds to nearest, with ties going toward plus infinity. For example, 1.5 gives 2 and -1.5 gives -1.
- R7: Coefficients are signed, CW bits wide, with CF fraction bits. They are written when `coef_we` is high, with this address map: 0 is b0, 1 is b1, 2+k is g[k] for k = 0..M-1, 2+M+(m-1) is P[m] and 2+2M+(m-1) is Q[m] for m = 1..M. Here g is the impulse response of the pole-only recursion, P[m] = g[m] and Q[m] = a2*g[m-1]. `coef_we` is never high in a cycle with `in_valid` high.
- R8: A synchronous reset during a stream discards all filter history. A block of zeros fed after it yields all-zero outputs, and an impulse fed after it yields the impulse response from rest. The coefficients keep their values through the reset.
- R9: With a1 = a2 = 0, the block is a two-tap FIR whose outputs match b0*x[n] + b1*x[n-1], rounded per R6, exactly. This holds across block boundaries, where x[n-1] is the last sample of the previous block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | $clog2(3*M+2) | Coefficient address (map in R7) |
| coef_data | input | CW | Signed coefficient, CF fraction bits |
| in_valid | input | 1 | Input block valid |
| in_data | input | M*DW | M signed input samples, lane 0 oldest |
| out_valid | output | 1 | Output block valid |
| out_data | output | M*DW | M signed output samples, lane 0 oldest |

## Verification
The assertions assume that coefficient writes never coincide with a valid input block, and that coefficients are stable while data is flowing. The bench meets this by loading every coefficient set with `in_valid` held low and only then streaming blocks. The internal state saturation is also assumed never to engage: the bench picks pole sets with magnitude at most 0.75, and its full-scale stimulus stays within the headroom of the state width. Under those conditions, the idle-cycle assertions and the bench's one-LSB comparison against a real-valued serial recursion are meaningful. Idle cycles carry junk on `in_data` so that R4 is exercised through the ports.

// File: rtl/lookahead_iir2.sv
module lookahead_iir2 #(
  parameter int DW = 16,
  parameter int M  = 4,
  parameter int G  = 8,
  parameter int HR = 4,
  parameter int CW = 20,
  parameter int CF = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          coef_we,
  input  logic [$clog2(3*M+2)-1:0]      coef_addr,
  input  logic signed [CW-1:0]          coef_data,
  input  logic                          in_valid,
  input  logic [M*DW-1:0]               in_data,
  output logic                          out_valid,
  output logic [M*DW-1:0]               out_data
);
  localparam int NC  = 3*M + 2;
  localparam int AW  = $clog2(NC);
  localparam int SW  = DW + G + HR;
  localparam int ACW = SW + CW + $clog2(M+2) + 1;
  localparam int IB  = 2;
  localparam int IP  = 2 + M;
  localparam int IQ  = 2 + 2*M;

  localparam logic signed [ACW-1:0] SMAX = {{(ACW-SW+1){1'b0}}, {(SW-1){1'b1}}};
  localparam logic signed [ACW-1:0] SMIN = ~SMAX;
  localparam logic signed [SW:0]    OMAX = {{(SW-DW+2){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [SW:0]    OMIN = ~OMAX;
  localparam logic signed [SW:0]    HALF = (SW+1)'(1) <<< (G-1);

  logic signed [CW-1:0] coef [NC];
  logic signed [SW-1:0] s_last, s_prev;
  logic signed [DW-1:0] x_last;
  logic signed [DW-1:0] xs [0:M];
  logic signed [SW-1:0] v  [1:M];
  logic signed [SW-1:0] yw [1:M];
  logic [M*DW-1:0]      y_out;

  function automatic logic signed [SW-1:0] clip_state(input logic signed [ACW-1:0] a);
    if (a > SMAX)      return SW'(SMAX);
    else if (a < SMIN) return SW'(SMIN);
    else               return SW'(a);
  endfunction

  function automatic logic signed [DW-1:0] to_out(input logic signed [SW-1:0] y);
    logic signed [SW:0] t;
    t = ((SW+1)'(y) + HALF) >>> G;
    if (t > OMAX)      return DW'(OMAX);
    else if (t < OMIN) return DW'(OMIN);
    else               return DW'(t);
  endfunction

  always_ff @(posedge clk)
    if (coef_we && ({1'b0, coef_addr} < (AW+1)'(NC)))
      coef[coef_addr] <= coef_data;

  assign xs[0] = x_last;
  for (genvar k = 1; k <= M; k++) begin : g_lane
    assign xs[k] = $signed(in_data[(k-1)*DW +: DW]);
    assign y_out[(k-1)*DW +: DW] = to_out(yw[k]);
  end

  always_comb begin
    for (int k = 1; k <= M; k++)
      v[k] = SW'((ACW'(coef[0]) * ACW'(xs[k]) + ACW'(coef[1]) * ACW'(xs[k-1])) >>> (CF - G));
    for (int m = 1; m <= M; m++) begin
      logic signed [ACW-1:0] acc;
      acc = ACW'(coef[IP+m-1]) * ACW'(s_last) + ACW'(coef[IQ+m-1]) * ACW'(s_prev);
      for (int k = 1; k <= m; k++)
        acc = acc + ACW'(coef[IB+m-k]) * ACW'(v[k]);
      yw[m] = clip_state(acc >>> CF);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_last    <= '0;
      s_prev    <= '0;
      x_last    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        s_last   <= yw[M];
        s_prev   <= yw[M-1];
        x_last   <= xs[M];
        out_data <= y_out;
      end
    end
  end

  p_valid_lat_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_out_r4: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_data)));
  p_idle_state_r4: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(s_last) && $stable(s_prev) && $stable(x_last)));
  p_coef_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    coef_we |-> !in_valid);
endmodule

// File: tb/lookahead_iir2_tb.sv
module lookahead_iir2_tb;
  localparam int DW = 16, M = 4, G = 8, HR = 4, CW = 20, CF = 16;
  localparam int AW = $clog2(3*M+2);

  logic clk = 1'b0, rst = 1'b1, coef_we = 1'b0, in_valid = 1'b0;
  logic [AW-1:0] coef_addr = '0;
  logic signed [CW-1:0] coef_data = '0;
  logic [M*DW-1:0] in_data = '0;
  logic out_valid;
  logic [M*DW-1:0] out_data;

  int nchk = 0, nerr = 0, nsat = 0;
  real rb0, rb1, ra1, ra2, ry1, ry2, rx1;

  lookahead_iir2 #(.DW(DW), .M(M), .G(G), .HR(HR), .CW(CW), .CF(CF)) u_dut (
    .clk(clk), .rst(rst), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_data(coef_data), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data));

  always #2 clk = ~clk;

  function automatic int rsat(input real y);
    real f;
    f = $floor(y + 0.5);
    if (f > 32767.0) return 32767;
    if (f < -32768.0) return -32768;
    return $rtoi(f);
  endfunction

  function automatic int lane(input int k);
    return int'($signed(out_data[k*DW +: DW]));
  endfunction

  task automatic check(input int act, input int exp, input int tol, input string req);
    nchk++;
    if (act - exp > tol || exp - act > tol) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input real v);
    @(negedge clk);
    in_valid = 1'b0;
    coef_we = 1'b1;
    coef_addr = AW'(a);
    coef_data = CW'($rtoi(v * real'(1 << CF)));
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  task automatic load(input real b0, input real b1, input real a1, input real a2);
    real h [0:M];
    rb0 = b0; rb1 = b1; ra1 = a1; ra2 = a2;
    h[0] = 1.0;
    h[1] = a1;
    for (int k = 2; k <= M; k++) h[k] = a1 * h[k-1] + a2 * h[k-2];
    wr(0, b0);
    wr(1, b1);
    for (int k = 0; k < M; k++) wr(2 + k, h[k]);
    for (int m = 1; m <= M; m++) begin
      wr(2 + M + m - 1, h[m]);
      wr(2 + 2*M + m - 1, a2 * h[m-1]);
    end
  endtask

  task automatic do_reset(input string req);
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    ry1 = 0.0; ry2 = 0.0; rx1 = 0.0;
    check(int'(out_valid), 0, 0, req);
    for (int k = 0; k < M; k++) check(lane(k), 0, 0, req);
  endtask

  task automatic blk(input int xs[M], input int tol, input string req);
    int e [M];
    real y;
    @(negedge clk);
    in_valid = 1'b1;
    for (int k = 0; k < M; k++) begin
      in_data[k*DW +: DW] = DW'(xs[k]);
      y = rb0 * xs[k] + rb1 * rx1 + ra1 * ry1 + ra2 * ry2;
      ry2 = ry1; ry1 = y; rx1 = real'(xs[k]);
      e[k] = rsat(y);
      if (e[k] == 32767 || e[k] == -32768) nsat++;
    end
    @(posedge clk);
    #1;
    check(int'(out_valid), 1, 0, "R2");
    for (int k = 0; k < M; k++) check(lane(k), e[k], tol, req);
  endtask

  task automatic idle();
    logic [M*DW-1:0] prev;
    prev = out_data;
    @(negedge clk);
    in_valid = 1'b0;
    in_data = {M{16'h5A3C}};
    @(posedge clk);
    #1;
    check(int'(out_valid), 0, 0, "R2");
    check(int'(out_data == prev), 1, 0, "R4");
  endtask

  initial begin
    #(4 * 150000);
    nerr++;
    $display("FAIL watchdog R2: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    int xs [M];
    repeat (3) @(negedge clk);
    do_reset("R1");

    // R7, R9: two-tap FIR through the coefficient map, exact across block edges
    load(0.75, -0.5, 0.0, 0.0);
    for (int j = 0; j < 24; j++) begin
      for (int k = 0; k < M; k++) xs[k] = (j * M + k) * 137 - 6000 + ((k % 2) ? 911 : -503);
      blk(xs, 0, "R7,R9");
    end

    // R6: half-LSB ties round toward plus infinity
    load(0.5, 0.0, 0.0, 0.0);
    for (int j = -8; j < 8; j++) begin
      for (int k = 0; k < M; k++) xs[k] = 2 * (j * M + k) + 1;
      blk(xs, 0, "R6");
    end

    // R3: impulse then noise with gaps
    do_reset("R1");
    load(1.0, 0.5, 0.5, -0.25);
    blk('{1000, 0, 0, 0}, 1, "R3");
    for (int j = 0; j < 6; j++) blk('{0, 0, 0, 0}, 1, "R3");
    for (int j = 0; j < 60; j++) begin
      for (int k = 0; k < M; k++) xs[k] = $urandom_range(4000) - 2000;
      blk(xs, 1, (j % 3 == 2) ? "R4" : "R3");
      if (j % 3 == 1) begin idle(); idle(); end
    end

    // R5: resonant poles, full-scale square wave near resonance
    load(1.0, 0.5, 1.25, -0.5625);
    nsat = 0;
    for (int j = 0; j < 40; j++) begin
      for (int k = 0; k < M; k++) xs[k] = (((j * M + k) % 10) < 5) ? 32000 : -32000;
      blk(xs, 1, "R5");
    end
    check(int'(nsat > 0), 1, 0, "R5");
    for (int j = 0; j < 30; j++) begin
      for (int k = 0; k < M; k++) xs[k] = $urandom_range(65535) - 32768;
      blk(xs, 1, "R3");
    end

    // R8: reset mid-stream discards history, keeps coefficients
    do_reset("R8");
    for (int j = 0; j < 3; j++) blk('{0, 0, 0, 0}, 0, "R8");
    blk('{3000, 0, 0, 0}, 1, "R8");
    for (int j = 0; j < 8; j++) blk('{0, 0, 0, 0}, 1, "R8");
    idle();

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule